// File: doc/BRIEF.md
# Chopped Motor Pulse Generator

This block drives the four switches of an H-bridge for one stepping-motor drive pulse, clocked from a 32768 Hz watch crystal. A one-cycle start strobe launches a pulse whose length is a whole number of 32-cycle chopping periods. The energy is set by the share of each period in which the bridge actually drives, not by the pulse length. At rest the two high-side switches are closed, so the winding is shorted. During the off part of each chopping period the bridge goes back to that shorted state.

An optional enlargement segment can follow the main pulse. It keeps the same direction, runs at a quarter duty, and lasts twice as many periods. For correction there is also a short reverse mode: one full-duty period in the opposite direction. The surrounding controller picks the drive level and runs step detection. This block only shapes the switch waveforms. Every change between driving and shorting passes through one cycle in which the switch being dropped is already off and the switch being added is not yet on.

Top module: `motor_pulse_gen`

## Requirements
- R1: During and after reset, with no pulse running, the high-side switches (hiLeftEn, hiRightEn) are on, the low-side switches (loLeftEn, loRightEn) are off, and pulseDone is low.
- R2: A non-reverse pulse lasts widthCode+1 periods of 32 cycles. The start strobe is sampled on a clock edge k, and the pulse's final period ends at edge k+32*(widthCode+1).
- R3: Each chopping period requests drive for its first 2*(dutyCode+1) cycles (dutyCode 15 = the whole period). The low-side switch is therefore seen on for that many cycles minus one per isolated period. When the code is 15, consecutive periods merge into one continuous drive.
- R4: dirSel=0 drives with hiRightEn and loLeftEn on and hiLeftEn and loRightEn off. dirSel=1 swaps the pairs: hiLeftEn and loRightEn are on.
- R5: When the bridge moves between shorted and driving, one intermediate cycle occurs in which only the switch common to both states is on. hiLeftEn and loLeftEn are never on together, and neither are hiRightEn and loRightEn.
- R6: With enlargeReq=1 in a non-reverse pulse, an extra segment of 2*(widthCode+1) periods follows the main pulse, in the same direction, driving for the first 8 cycles of each period.
- R7: With reverseMode=1 the pulse is one period at full duty in the direction opposite to dirSel. dutyCode, widthCode and enlargeReq have no effect.
- R8: pulseDone is high for exactly one cycle, in the cycle right after the last cycle of the final period (the enlargement segment's last period when one is used).
- R9: A start strobe that arrives while a pulse is running is ignored. It does not restart, extend or queue a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz clock |
| rstN | input | 1 | asynchronous reset, active low |
| startStb | input | 1 | one-cycle request to launch a pulse |
| dirSel | input | 1 | drive direction |
| dutyCode | input | 4 | chopping duty, on-time 2*(code+1) cycles |
| widthCode | input | 3 | pulse width, code+1 periods |
| enlargeReq | input | 1 | append the quarter-duty enlargement segment |
| reverseMode | input | 1 | short full-duty reverse correction pulse |
| hiLeftEn | output | 1 | high-side switch, left leg |
| hiRightEn | output | 1 | high-side switch, right leg |
| loLeftEn | output | 1 | low-side switch, left leg |
| loRightEn | output | 1 | low-side switch, right leg |
| pulseDone | output | 1 | one-cycle end-of-pulse strobe |

## Verification
Each output has a fixed latency from the start strobe sampled at edge k. The drive request begins in the cycle after k. The switch outputs are registered once more, so the first output change, a break-before-make cycle, appears in the second cycle after k, and full drive appears in the third. pulseDone rises exactly 32 times the period count after k. The bench's reference model keeps a per-cycle queue of requested bridge states. It pops one entry per edge and applies the register delay and the break-before-make step, and the outputs are compared with it at every falling edge. Each pulse also checks the start-to-done latency and the total low-side on cycles, and those totals include the cycles after pulseDone in which the last drive is still unwinding.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

  // Command handed from the sequencer to the bridge datapath each cycle
  typedef struct packed {
    logic driveReq;  // drive window active in this cycle
    logic dirRev;    // 1: left-high / right-low pair drives
  } bridgeCmd_t;

  typedef enum logic [1:0] {
    SEG_IDLE  = 2'd0,
    SEG_MAIN  = 2'd1,
    SEG_EXTRA = 2'd2
  } seg_t;

  // Bit positions inside the 4-bit switch vector
  localparam int SW_HL = 3;
  localparam int SW_HR = 2;
  localparam int SW_LL = 1;
  localparam int SW_LR = 0;

endpackage

// File: rtl/mpg_ctrl.sv
module mpg_ctrl
  import mpg_pkg::*;
#(
  parameter int PERIOD   = 32,
  parameter int DUTY_W   = 4,
  parameter int WIDTH_W  = 3,
  parameter int ENL_ON   = 8,
  parameter int ENL_MULT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic               dirSel,
  input  logic [DUTY_W-1:0]  dutyCode,
  input  logic [WIDTH_W-1:0] widthCode,
  input  logic               enlargeReq,
  input  logic               reverseMode,
  output bridgeCmd_t         cmd,
  output logic               pulseDone
);

  localparam int PH_W  = $clog2(PERIOD);
  localparam int ON_W  = $clog2(PERIOD + 1);
  localparam int CNT_W = WIDTH_W + $clog2(ENL_MULT) + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  seg_t               seg;
  logic [PH_W-1:0]    phase;
  logic [CNT_W-1:0]   periodIdx;
  logic [CNT_W-1:0]   lastPeriod;
  logic [WIDTH_W-1:0] mainWidth;
  logic [ON_W-1:0]    onLen;
  logic               dirLat;
  logic               enlLat;

  logic [ON_W-1:0]    onCalc;
  logic [CNT_W-1:0]   extraLast;
  logic               launch;
  logic               periodEnd;
  logic               segEnd;

  // On-time from the duty code, saturated to the full period
  always_comb begin
    int onTmp;
    onTmp = 2 * (int'(dutyCode) + 1);
    if (onTmp > PERIOD) onTmp = PERIOD;
    onCalc = ON_W'(onTmp);
  end

  assign extraLast = CNT_W'(ENL_MULT * (int'(mainWidth) + 1) - 1);
  assign launch    = startStb && (seg == SEG_IDLE);
  assign periodEnd = (seg != SEG_IDLE) && (phase == PH_LAST);
  assign segEnd    = periodEnd && (periodIdx == lastPeriod);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seg        <= SEG_IDLE;
      phase      <= '0;
      periodIdx  <= '0;
      lastPeriod <= '0;
      mainWidth  <= '0;
      onLen      <= '0;
      dirLat     <= 1'b0;
      enlLat     <= 1'b0;
      pulseDone  <= 1'b0;
    end else begin
      pulseDone <= 1'b0;
      if (launch) begin
        seg       <= SEG_MAIN;
        phase     <= '0;
        periodIdx <= '0;
        if (reverseMode) begin
          lastPeriod <= '0;
          mainWidth  <= '0;
          onLen      <= ON_W'(PERIOD);
          dirLat     <= ~dirSel;
          enlLat     <= 1'b0;
        end else begin
          lastPeriod <= CNT_W'(widthCode);
          mainWidth  <= widthCode;
          onLen      <= onCalc;
          dirLat     <= dirSel;
          enlLat     <= enlargeReq;
        end
      end else if (seg != SEG_IDLE) begin
        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        if (segEnd) begin
          periodIdx <= '0;
          if (seg == SEG_MAIN && enlLat) begin
            seg        <= SEG_EXTRA;
            lastPeriod <= extraLast;
            onLen      <= ON_W'(ENL_ON);
          end else begin
            seg       <= SEG_IDLE;
            pulseDone <= 1'b1;
          end
        end else if (periodEnd) begin
          periodIdx <= periodIdx + 1'b1;
        end
      end
    end
  end

  assign cmd.driveReq = (seg != SEG_IDLE) && (ON_W'(phase) < onLen);
  assign cmd.dirRev   = dirLat;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseDone |=> !pulseDone);

  // R8
  done_after_last_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseDone) |-> ($past(phase) == PH_LAST));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seg != SEG_IDLE && startStb) |=> $stable(dirLat) && $stable(mainWidth));

  // R2
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seg == SEG_IDLE) |-> !cmd.driveReq);

endmodule

// File: rtl/mpg_bridge.sv
module mpg_bridge
  import mpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  bridgeCmd_t cmd,
  output logic [3:0] swOut
);

  localparam logic [3:0] SW_SHORT = (4'b1 << SW_HL) | (4'b1 << SW_HR);
  localparam logic [3:0] SW_FWD   = (4'b1 << SW_HR) | (4'b1 << SW_LL);
  localparam logic [3:0] SW_REV   = (4'b1 << SW_HL) | (4'b1 << SW_LR);

  logic [3:0] target;
  logic [3:0] adding;
  logic [3:0] dropping;
  logic [3:0] nextSw;

  always_comb begin
    if (!cmd.driveReq)   target = SW_SHORT;
    else if (cmd.dirRev) target = SW_REV;
    else                 target = SW_FWD;
  end

  assign adding   = target & ~swOut;
  assign dropping = swOut & ~target;
  // When switches are both added and removed, release first
  assign nextSw   = ((adding != '0) && (dropping != '0)) ? (swOut & target) : target;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swOut <= SW_SHORT;
    else       swOut <= nextSw;
  end

  // R5
  left_leg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(swOut[SW_HL] && swOut[SW_LL]));

  // R5
  right_leg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(swOut[SW_HR] && swOut[SW_LR]));

  // R5
  left_bbm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swOut[SW_LL]) |-> !$past(swOut[SW_HL]));

  // R4
  fwd_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.driveReq && !cmd.dirRev) |=> !swOut[SW_LR]);

endmodule

// File: rtl/motor_pulse_gen.sv
module motor_pulse_gen
  import mpg_pkg::*;
#(
  parameter int PERIOD   = 32,
  parameter int DUTY_W   = 4,
  parameter int WIDTH_W  = 3,
  parameter int ENL_ON   = 8,
  parameter int ENL_MULT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic               dirSel,
  input  logic [DUTY_W-1:0]  dutyCode,
  input  logic [WIDTH_W-1:0] widthCode,
  input  logic               enlargeReq,
  input  logic               reverseMode,
  output logic               hiLeftEn,
  output logic               hiRightEn,
  output logic               loLeftEn,
  output logic               loRightEn,
  output logic               pulseDone
);

  bridgeCmd_t cmd;
  logic [3:0] swOut;

  mpg_ctrl #(
    .PERIOD(PERIOD), .DUTY_W(DUTY_W), .WIDTH_W(WIDTH_W),
    .ENL_ON(ENL_ON), .ENL_MULT(ENL_MULT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startStb(startStb), .dirSel(dirSel),
    .dutyCode(dutyCode), .widthCode(widthCode), .enlargeReq(enlargeReq),
    .reverseMode(reverseMode), .cmd(cmd), .pulseDone(pulseDone)
  );

  mpg_bridge uBridge (
    .clk(clk), .rstN(rstN), .cmd(cmd), .swOut(swOut)
  );

  assign hiLeftEn  = swOut[SW_HL];
  assign hiRightEn = swOut[SW_HR];
  assign loLeftEn  = swOut[SW_LL];
  assign loRightEn = swOut[SW_LR];

endmodule

// File: tb/sim_motor_pulse_gen.sv
module sim_motor_pulse_gen;

  localparam int CLK_PERIOD = 30518;
  localparam int PER = 32;
  localparam logic [3:0] V_SHORT = 4'b1100;
  localparam logic [3:0] V_FWD   = 4'b0110;
  localparam logic [3:0] V_REV   = 4'b1001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startStb = 1'b0;
  logic dirSel = 1'b0;
  logic [3:0] dutyCode = '0;
  logic [2:0] widthCode = '0;
  logic enlargeReq = 1'b0;
  logic reverseMode = 1'b0;
  logic hiLeftEn, hiRightEn, loLeftEn, loRightEn, pulseDone;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int doneSeen = 0;
  string curTag = "R1";
  bit finished = 1'b0;

  int reqQ[$];
  logic [3:0] mApp = V_SHORT;
  logic mDone = 1'b0;

  motor_pulse_gen u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .dirSel(dirSel),
    .dutyCode(dutyCode), .widthCode(widthCode), .enlargeReq(enlargeReq),
    .reverseMode(reverseMode), .hiLeftEn(hiLeftEn), .hiRightEn(hiRightEn),
    .loLeftEn(loLeftEn), .loRightEn(loRightEn), .pulseDone(pulseDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] codeVec(int c);
    if (c == 1) return V_FWD;
    if (c == 2) return V_REV;
    return V_SHORT;
  endfunction

  // Behavioural schedule: one entry per cycle, code 0 short, 1/2 drive, +8 marks last
  task automatic buildSchedule();
    int nMain, onMain, dcode, total, idx;
    if (reverseMode) begin
      nMain = 1; onMain = PER; dcode = dirSel ? 1 : 2;
    end else begin
      nMain = int'(widthCode) + 1;
      onMain = 2 * (int'(dutyCode) + 1);
      dcode = dirSel ? 2 : 1;
    end
    total = nMain * PER;
    if (!reverseMode && enlargeReq) total += 2 * nMain * PER;
    idx = 0;
    for (int p = 0; p < nMain; p++)
      for (int ph = 0; ph < PER; ph++) begin
        idx++;
        reqQ.push_back(((ph < onMain) ? dcode : 0) + ((idx == total) ? 8 : 0));
      end
    if (!reverseMode && enlargeReq)
      for (int p = 0; p < 2 * nMain; p++)
        for (int ph = 0; ph < PER; ph++) begin
          idx++;
          reqQ.push_back(((ph < 8) ? dcode : 0) + ((idx == total) ? 8 : 0));
        end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ.delete();
      mApp = V_SHORT;
      mDone = 1'b0;
    end else begin
      int item;
      logic [3:0] req;
      bit wasIdle;
      wasIdle = (reqQ.size() == 0);
      item = wasIdle ? 0 : reqQ.pop_front();
      req = codeVec(item % 8);
      if (((req & ~mApp) != 0) && ((mApp & ~req) != 0)) mApp = mApp & req;
      else mApp = req;
      mDone = (item >= 8);
      if (wasIdle && startStb) buildSchedule();
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Per-cycle comparison against the model; R5 leg exclusion folded in
  always @(negedge clk) begin
    if (rstN && !finished) begin
      logic [3:0] act;
      act = {hiLeftEn, hiRightEn, loLeftEn, loRightEn};
      checks++;
      if (act != mApp || pulseDone != mDone || (hiLeftEn && loLeftEn) || (hiRightEn && loRightEn)) begin
        errors++;
        $display("FAIL %s/R5 cycle %0d switches %b done %b expected %b done %b",
                 curTag, cycles, act, pulseDone, mApp, mDone);
      end
      if (pulseDone) doneSeen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog expired actual %0d cycles expected under 150000", cycles);
      summary();
    end
  end

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic runPulse(string tag, bit d, bit rev, bit enl, int duty, int width,
                          int busyAt, int expLat, int expLl, int expLr);
    int lat, nLl, nLr;
    bit got;
    curTag = tag;
    @(negedge clk);
    dirSel = d; reverseMode = rev; enlargeReq = enl;
    dutyCode = 4'(duty); widthCode = 3'(width);
    startStb = 1'b1;
    lat = 0; nLl = 0; nLr = 0; got = 1'b0;
    while (!got && lat < 3000) begin
      @(negedge clk);
      lat++;
      startStb = (lat == busyAt);
      if (lat == busyAt) begin
        dirSel = ~d; widthCode = 3'd7; enlargeReq = 1'b1;
      end
      nLl += int'(loLeftEn);
      nLr += int'(loRightEn);
      got = pulseDone;
    end
    startStb = 1'b0;
    repeat (3) begin
      @(negedge clk);
      nLl += int'(loLeftEn);
      nLr += int'(loRightEn);
    end
    check(tag, lat, expLat, "start-to-done cycles (R2/R8)");
    check(tag, nLl, expLl, "left low-side on cycles");
    check(tag, nLr, expLr, "right low-side on cycles");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'({hiLeftEn, hiRightEn, loLeftEn, loRightEn, pulseDone}), 5'b11000, "outputs in reset");
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", int'({hiLeftEn, hiRightEn, loLeftEn, loRightEn, pulseDone}), 5'b11000, "outputs idle");

    // R3: minimum duty, one period
    runPulse("R3", 1'b0, 1'b0, 1'b0, 0, 0, 0, PER + 1, 1, 0);
    // R4: reverse direction pair, 3 periods, 16-cycle window
    runPulse("R4", 1'b1, 1'b0, 1'b0, 7, 2, 0, 3 * PER + 1, 0, 45);
    // R3: full duty merges periods
    runPulse("R3", 1'b0, 1'b0, 1'b0, 15, 1, 0, 2 * PER + 1, 63, 0);
    // R6: enlargement segment
    runPulse("R6", 1'b0, 1'b0, 1'b1, 3, 0, 0, 3 * PER + 1, 21, 0);
    // R7: reverse correction pulse ignores duty/width/enlarge
    runPulse("R7", 1'b0, 1'b1, 1'b1, 0, 7, 0, PER + 1, 0, 31);
    // R9: start while busy is ignored
    runPulse("R9", 1'b0, 1'b0, 1'b0, 3, 1, 20, 2 * PER + 1, 14, 0);
    curTag = "R9";
    repeat (80) @(negedge clk);
    // R8: one done per accepted pulse
    check("R8", doneSeen, 6, "done strobes counted");
    check("R1", int'({hiLeftEn, hiRightEn, loLeftEn, loRightEn}), 4'b1100, "bridge shorted after pulses");
    summary();
  end

endmodule